// File: doc/BRIEF.md
# Auxiliary Channel Lock Register

This block arbitrates one auxiliary channel between two agents: software on a register bus, and a hardware engine that starts channel transactions on its own. Software takes the lock by reading the register, because a read has a side effect: it requests the lock. Software frees the lock by writing the register. The hardware engine uses a level request, a grant and a one-cycle release pulse.

The register holds three things:
- Bit 31 turns arbitration on.
- Bit 30 reports the result of the read that returned it.
- Bits 29:0 are kept as plain storage, so that software can write back what it read without changing them.

A 2-bit owner output reports who holds the channel in every cycle.

Read data is registered. It is valid from the cycle after the read strobe, and the owner outputs change in that same cycle.

Top module: `aux_lock_reg`

## Requirements
- R1: After reset, arbitration is off, the read data is all zero, the owner output is 2'b00 (free), and `hw_grant` is 0.
- R2: While bit 31 is 0, a read does not lock. It returns bit 30 as 0, and `chan_owner` never becomes 2'b01 (software).
- R3: While bit 31 is 1 and the lock is free, a read takes the lock for software. The returned bit 30 is 0 and `chan_owner` becomes 2'b01. A further read by the owner again returns 0 and keeps the lock.
- R4: A read while the hardware engine holds the lock returns bit 30 as 1 and takes nothing. Repeating the read after the release acquires the lock.
- R5: A write with bit 30 = 1 while software owns the lock frees it. A write with bit 30 = 0, or any write while software is not the owner, leaves ownership unchanged.
- R6: Bits 31 and 29:0 read back exactly as last written.
- R7: When the lock is free, `hw_req` gives `hw_grant` = 1 (owner 2'b10) from the next cycle. The grant holds until a `hw_release` pulse, and the lock is free in the cycle after that pulse.
- R8: If a software read and `hw_req` arrive in the same cycle while the lock is free, the hardware engine wins and the read returns bit 30 as 1.
- R9: A write with bit 31 = 0 frees a lock held by software. While bit 31 is 0, the hardware engine is granted as soon as the lock is free.
- R10: A hardware request made while software owns the lock waits. It is granted the cycle after software frees the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe; ignored when `reg_wr` is also high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| hw_req | input | 1 | Hardware engine lock request, held until granted |
| hw_release | input | 1 | One-cycle pulse from the hardware engine to free its lock |
| hw_grant | output | 1 | Hardware engine holds the lock |
| chan_owner | output | 2 | 00 free, 01 software, 10 hardware engine |

## Verification
The bench aims at the cases where arbitration can go wrong:
- **Simultaneous request.** A read and a hardware request in the same cycle. A design that let software win would return 0 in bit 30 while also raising the grant.
- **Non-owner and zero-bit writes.** A write from a non-owner, and a write with bit 30 clear. A design that released on any write would strip a lock from the hardware engine, or from software.
- **Read-backs.** Reads while disabled must not lock, and the storage bits must survive every write. A design that stored bit 30, or that locked regardless of bit 31, is caught by the read-back values.
- **Waiting hardware request.** A hardware request held while software owns the lock must be granted exactly one cycle after the release write, and not before it.

// File: rtl/aux_lock_reg.sv
module aux_lock_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        hw_req,
  input  logic        hw_release,
  output logic        hw_grant,
  output logic [1:0]  chan_owner
);
  localparam logic [1:0] OWN_FREE = 2'b00;
  localparam logic [1:0] OWN_SW   = 2'b01;
  localparam logic [1:0] OWN_HW   = 2'b10;

  logic [1:0]  owner_q, owner_d;
  logic        en_q;
  logic [29:0] keep_q;
  logic [31:0] rdata_q;
  logic        sw_rd;

  assign sw_rd = reg_rd && !reg_wr;

  always_comb begin
    owner_d = owner_q;
    case (owner_q)
      OWN_FREE: begin
        if (hw_req)              owner_d = OWN_HW;
        else if (sw_rd && en_q)  owner_d = OWN_SW;
      end
      OWN_SW: begin
        if (reg_wr && (reg_wdata[30] || !reg_wdata[31])) owner_d = OWN_FREE;
      end
      OWN_HW: begin
        if (hw_release) owner_d = OWN_FREE;
      end
      default: owner_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_FREE;
      en_q    <= 1'b0;
      keep_q  <= '0;
      rdata_q <= '0;
    end else begin
      owner_q <= owner_d;
      if (reg_wr) begin
        en_q   <= reg_wdata[31];
        keep_q <= reg_wdata[29:0];
      end else if (reg_rd) begin
        rdata_q <= {en_q, en_q && (owner_d != OWN_SW), keep_q};
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign chan_owner = owner_q;
  assign hw_grant   = (owner_q == OWN_HW);

  // R3/R4: returned status bit agrees with the resulting ownership
  p_status_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && en_q) |=> (reg_rdata[30] == (chan_owner != OWN_SW)));

  // R2: no software lock while disabled
  p_disabled_no_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && chan_owner != OWN_SW && !reg_wr) |=> (chan_owner != OWN_SW));

  // R5: release write by the owner frees the lock
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_owner == OWN_SW && reg_wr && reg_wdata[30]) |=> (chan_owner == OWN_FREE));

  // R7: the grant holds until the release pulse
  p_hw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_grant && !hw_release) |=> hw_grant);

  // R8: hardware wins a same-cycle contest
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_owner == OWN_FREE && hw_req && sw_rd) |=> (hw_grant && reg_rdata[30] == en_q));

  // R9: clearing the enable bit frees software ownership
  p_disable_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[31]) |=> (chan_owner != OWN_SW));
endmodule

// File: tb/aux_lock_reg_test.sv
module aux_lock_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hw_req = 1'b0, hw_release = 1'b0;
  logic        hw_grant;
  logic [1:0]  chan_owner;
  int total = 0, bad = 0;

  aux_lock_reg uut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .hw_release(hw_release), .hw_grant(hw_grant), .chan_owner(chan_owner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk) reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0;
  endtask

  task automatic do_write(logic [31:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic hw_take();
    @(negedge clk) hw_req = 1'b1;
    @(negedge clk) hw_req = 1'b0;
  endtask

  task automatic hw_free();
    @(negedge clk) hw_release = 1'b1;
    @(negedge clk) hw_release = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 owner", {30'd0, chan_owner}, 32'd0);
    check("R1 grant", {31'd0, hw_grant}, 32'd0);
  endtask

  task automatic t_disabled();
    do_write(32'h0000_1234);
    do_read();
    check("R2 rdata", reg_rdata, 32'h0000_1234);
    check("R2 owner", {30'd0, chan_owner}, 32'd0);
  endtask

  task automatic t_acquire();
    do_write(32'h8000_1234);
    do_read();
    check("R3 rdata", reg_rdata, 32'h8000_1234);
    check("R3 owner", {30'd0, chan_owner}, 32'd1);
    do_read();
    check("R3 reread", reg_rdata, 32'h8000_1234);
    check("R3 reread owner", {30'd0, chan_owner}, 32'd1);
  endtask

  task automatic t_sw_release();
    do_write(32'h8000_1234);
    check("R5 zero bit keeps", {30'd0, chan_owner}, 32'd1);
    @(negedge clk) hw_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 hw waits", {31'd0, hw_grant}, 32'd0);
    do_write(32'hC000_1234);
    check("R5 released", {30'd0, chan_owner}, 32'd0);
    @(negedge clk);
    check("R10 hw granted", {30'd0, chan_owner}, 32'd2);
    hw_req = 1'b0;
  endtask

  task automatic t_hw_held();
    repeat (4) @(negedge clk);
    check("R7 grant held", {31'd0, hw_grant}, 32'd1);
    do_read();
    check("R4 busy status", reg_rdata, 32'hC000_1234);
    check("R4 no take", {30'd0, chan_owner}, 32'd2);
    do_write(32'hC000_1234);
    check("R5 non-owner write", {31'd0, hw_grant}, 32'd1);
    hw_free();
    check("R7 freed", {30'd0, chan_owner}, 32'd0);
    do_read();
    check("R4 retry acquires", reg_rdata, 32'h8000_1234);
    check("R4 owner", {30'd0, chan_owner}, 32'd1);
    do_write(32'hC000_1234);
  endtask

  task automatic t_tie();
    @(negedge clk) begin reg_rd = 1'b1; hw_req = 1'b1; end
    @(negedge clk) begin reg_rd = 1'b0; hw_req = 1'b0; end
    check("R8 grant", {30'd0, chan_owner}, 32'd2);
    check("R8 status", reg_rdata, 32'hC000_1234);
    hw_free();
  endtask

  task automatic t_disable_frees();
    do_read();
    check("R9 pre owner", {30'd0, chan_owner}, 32'd1);
    do_write(32'h0000_0055);
    check("R9 freed", {30'd0, chan_owner}, 32'd0);
    hw_take();
    check("R9 hw while off", {30'd0, chan_owner}, 32'd2);
    hw_free();
    do_read();
    check("R6 readback off", reg_rdata, 32'h0000_0055);
  endtask

  task automatic t_storage();
    do_write(32'h9ABC_DEF0);
    do_read();
    check("R6 readback on", reg_rdata, 32'h9ABC_DEF0);
    do_write(32'h7FFF_FFFF);
    do_read();
    check("R6 bit30 not stored", reg_rdata, 32'h3FFF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_acquire();
    t_sw_release();
    t_hw_held();
    t_tie();
    t_disable_frees();
    t_storage();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule